// File: doc/BRIEF.md
# Tape Controller DMA Data Path

This block sits between a magnetic tape controller, a shared 16-bit system bus with active-low data lines, and a byte-wide tape formatter port. During a block transfer an external transfer adapter owns the bus. The adapter signals this with an active-low input, and it marks the completion of each bus data transfer with a one-cycle pulse. Bus arbitration, the memory controller and the formatter are outside the block. They appear here only as handshake pins.

A control word selects the direction. In write mode the block arms a write flag and requests a bus word. When the transfer completes, it inverts the low byte of the bus lines and captures it into an output register. The registered byte goes to the formatter over a valid/ready stream. Once the formatter accepts it, the next word is requested. In read mode the block takes 16-bit words from the formatter over a second valid/ready stream and drives them, inverted, onto the bus through three transceiver strobes. The formatter word is consumed when the bus transfer completes.

An active-low end-of-block input stops the load path and raises an interrupt request. While the interrupt is acknowledged, the block drives its device number onto the bus. The number is zero-extended and active-low, and it uses the same strobes as read data. Bus drivers are modelled as a strobe vector plus a data-out word, not as tri-state nets.

Top module: `tape_dma_datapath`

## Requirements
- R1: After reset: write_armed, fmt_out_valid, irq_req, overrun and all bus_strobe bits are 0, and bus_dout_n is all ones.
- R2: A cycle with ctrl_load=1 sets the mode from ctrl_write_mode (1 = write, 0 = read). In write mode it sets write_armed and clears overrun and irq_req. In read mode it clears write_armed. word_req equals write_armed while the adapter owns the bus and end of block is not active.
- R3: When xfer_done=1 in a cycle with write_armed=1, write mode, bus_own_n=0 and blk_end_n=1, then at the next edge fmt_out_data becomes the bitwise inverse of bus_din_n[7:0], fmt_out_valid becomes 1, and write_armed becomes 0.
- R4: A xfer_done pulse when write_armed=0 or bus_own_n=1 leaves fmt_out_data and fmt_out_valid unchanged.
- R5: While fmt_out_valid=1 and fmt_out_ready=0, fmt_out_valid stays 1 and fmt_out_data holds (unless R6 applies). An accept (valid and ready) clears fmt_out_valid and re-arms write_armed in write mode when no interrupt is pending.
- R6: A load while fmt_out_valid=1 and fmt_out_ready=0 sets overrun. overrun stays set until the next ctrl_load.
- R7: In read mode, with bus_own_n=0, fmt_in_valid=1 and no interrupt pending or end of block, all three bus_strobe bits are 1 and bus_dout_n is ~fmt_in_data in the same cycle. fmt_in_ready equals xfer_done in that cycle and is 0 otherwise.
- R8: blk_end_n=0 blocks any load in that cycle. At the next edge it clears write_armed and sets irq_req.
- R9: While irq_req=1 and irq_ack=1, all bus_strobe bits are 1 and bus_dout_n is ~{8'h00, DEV_NUM}.
- R10: The bus_strobe bits are always all equal, and they are never 1 in a cycle where a load captures the bus.
- R11: With bus_own_n=1, word_req is 0 and no strobe is asserted except during an interrupt acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_load | input | 1 | Control register write strobe |
| ctrl_write_mode | input | 1 | Mode bit of the control word, 1 = write |
| bus_own_n | input | 1 | Active-low: transfer adapter owns the bus |
| xfer_done | input | 1 | One-cycle pulse: bus data transfer complete |
| blk_end_n | input | 1 | Active-low end of block from the adapter |
| bus_din_n | input | 16 | Bus data lines as received, active-low |
| bus_dout_n | output | 16 | Bus data to drive, active-low |
| bus_strobe | output | 3 | Transceiver drive enables |
| word_req | output | 1 | Request for the next bus word in write mode |
| write_armed | output | 1 | Write-busy flag |
| fmt_out_valid | output | 1 | Byte to formatter is valid |
| fmt_out_ready | input | 1 | Formatter accepts the byte |
| fmt_out_data | output | 8 | Byte to formatter |
| fmt_in_valid | input | 1 | Formatter word for the bus is valid |
| fmt_in_ready | output | 1 | Formatter word consumed by the bus |
| fmt_in_data | input | 16 | Formatter word for the bus |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| overrun | output | 1 | Sticky: byte overwritten before accept |

## Verification
The bench builds the block with DEV_NUM set to 8'h5C instead of the default, so the device-number drive is checked against a value that differs from the default and has mixed bits in both nibbles. The bus and byte widths keep their defaults, 16 and 8. With these widths the bench can check the inversion of the low byte, the separate high byte of read data, and the zero-extended high byte of the device number.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } tdp_mode_e;
endpackage

// File: rtl/tdp_ctrl.sv
module tdp_ctrl
  import tdp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_load,
  input  logic ctrl_write_mode,
  input  logic end_blk,
  input  logic load,
  input  logic accept,
  output logic mode_wr,
  output logic wr_busy,
  output logic irq_pend
);
  tdp_mode_e mode_q;
  logic      busy_q;
  logic      irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_READ;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_load) begin
        mode_q <= ctrl_write_mode ? MODE_WRITE : MODE_READ;
        busy_q <= ctrl_write_mode;
        irq_q  <= 1'b0;
      end else begin
        if (end_blk) begin
          busy_q <= 1'b0;
          irq_q  <= 1'b1;
        end else if (load) begin
          busy_q <= 1'b0;
        end else if (accept && mode_q == MODE_WRITE && !irq_q) begin
          busy_q <= 1'b1;
        end
      end
    end
  end

  assign mode_wr  = (mode_q == MODE_WRITE);
  assign wr_busy  = busy_q;
  assign irq_pend = irq_q;

  // R8: end of block disarms the write path and raises the interrupt
  assert_end_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_blk && !ctrl_load) |=> (!wr_busy && irq_pend));

  // R3: a completed load leaves the write flag cleared
  assert_load_clears_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ctrl_load) |=> !wr_busy);
endmodule

// File: rtl/tdp_wr_path.sv
module tdp_wr_path #(
  parameter int BUS_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              clr_ovr,
  input  logic [BUS_W-1:0]  bus_in_n,
  input  logic              fmt_ready,
  output logic [BYTE_W-1:0] fmt_data,
  output logic              fmt_valid,
  output logic              accept,
  output logic              ovr
);
  logic [BYTE_W-1:0] byte_q;
  logic              valid_q;
  logic              ovr_q;

  assign accept = valid_q && fmt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (load) begin
        byte_q  <= ~bus_in_n[BYTE_W-1:0];
        valid_q <= 1'b1;
      end else if (accept) begin
        valid_q <= 1'b0;
      end
      if (clr_ovr)
        ovr_q <= 1'b0;
      else if (load && valid_q && !fmt_ready)
        ovr_q <= 1'b1;
    end
  end

  assign fmt_data  = byte_q;
  assign fmt_valid = valid_q;
  assign ovr       = ovr_q;

  // R3: a load presents a valid byte at the next edge
  assert_load_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> fmt_valid);

  // R5: a stalled byte is held stable
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_valid && !fmt_ready && !load) |=> (fmt_valid && $stable(fmt_data)));

  // R6: overrun only rises after a load onto a pending byte
  assert_overrun_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(load && fmt_valid && !fmt_ready));
endmodule

// File: rtl/tdp_bus_drv.sv
module tdp_bus_drv #(
  parameter int              BUS_W   = 16,
  parameter int              N_STB   = 3,
  parameter int              DEV_W   = 8,
  parameter logic [DEV_W-1:0] DEV_NUM = 8'h17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             read_en,
  input  logic             ack_en,
  input  logic             capture,
  input  logic [BUS_W-1:0] rd_data,
  output logic [N_STB-1:0] strobe,
  output logic [BUS_W-1:0] dout_n
);
  localparam int PAD_W = BUS_W - DEV_W;
  localparam logic [BUS_W-1:0] DEV_WORD = {{PAD_W{1'b0}}, DEV_NUM};

  logic             drive_en;
  logic [BUS_W-1:0] word;

  assign drive_en = (read_en || ack_en) && !capture;

  always_comb begin
    if (ack_en)       word = DEV_WORD;
    else if (read_en) word = rd_data;
    else              word = '0;
  end

  for (genvar s = 0; s < N_STB; s++) begin : g_stb
    assign strobe[s] = drive_en;
  end

  assign dout_n = drive_en ? ~word : '1;

  // R10: no drive in a capture cycle
  assert_no_drive_on_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (strobe == '0));

  // R10: strobes move together
  assert_strobes_equal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe == '0) || (strobe == '1));

  // R9: acknowledge drives the device number
  assert_ack_devnum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_en && !capture) |-> (dout_n == ~DEV_WORD));
endmodule

// File: rtl/tape_dma_datapath.sv
module tape_dma_datapath
  import tdp_pkg::*;
#(
  parameter int              BUS_W   = 16,
  parameter int              BYTE_W  = 8,
  parameter int              N_STB   = 3,
  parameter logic [BYTE_W-1:0] DEV_NUM = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_load,
  input  logic              ctrl_write_mode,
  input  logic              bus_own_n,
  input  logic              xfer_done,
  input  logic              blk_end_n,
  input  logic [BUS_W-1:0]  bus_din_n,
  output logic [BUS_W-1:0]  bus_dout_n,
  output logic [N_STB-1:0]  bus_strobe,
  output logic              word_req,
  output logic              write_armed,
  output logic              fmt_out_valid,
  input  logic              fmt_out_ready,
  output logic [BYTE_W-1:0] fmt_out_data,
  input  logic              fmt_in_valid,
  output logic              fmt_in_ready,
  input  logic [BUS_W-1:0]  fmt_in_data,
  output logic              irq_req,
  input  logic              irq_ack,
  output logic              overrun
);
  logic own, end_blk, load, accept, mode_wr, wr_busy, irq_pend, read_en, ack_en;

  assign own     = ~bus_own_n;
  assign end_blk = ~blk_end_n;
  assign load    = xfer_done && own && wr_busy && mode_wr && !end_blk;
  assign read_en = own && !mode_wr && fmt_in_valid && !irq_pend && !end_blk;
  assign ack_en  = irq_pend && irq_ack;

  tdp_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_load      (ctrl_load),
    .ctrl_write_mode(ctrl_write_mode),
    .end_blk        (end_blk),
    .load           (load),
    .accept         (accept),
    .mode_wr        (mode_wr),
    .wr_busy        (wr_busy),
    .irq_pend       (irq_pend)
  );

  tdp_wr_path #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .clr_ovr  (ctrl_load),
    .bus_in_n (bus_din_n),
    .fmt_ready(fmt_out_ready),
    .fmt_data (fmt_out_data),
    .fmt_valid(fmt_out_valid),
    .accept   (accept),
    .ovr      (overrun)
  );

  tdp_bus_drv #(.BUS_W(BUS_W), .N_STB(N_STB), .DEV_W(BYTE_W), .DEV_NUM(DEV_NUM)) u_drv (
    .clk    (clk),
    .rst_n  (rst_n),
    .read_en(read_en),
    .ack_en (ack_en),
    .capture(load),
    .rd_data(fmt_in_data),
    .strobe (bus_strobe),
    .dout_n (bus_dout_n)
  );

  assign word_req     = wr_busy && own && !end_blk;
  assign write_armed  = wr_busy;
  assign fmt_in_ready = read_en && xfer_done;
  assign irq_req      = irq_pend;

  // R11: no request and no data strobes without bus ownership
  assert_no_req_unowned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_own_n |-> (!word_req && (irq_ack || bus_strobe == '0)));

  // R7: read handshake only completes on a bus transfer
  assert_read_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_in_ready |-> (xfer_done && bus_strobe == '1));
endmodule

// File: tb/tape_dma_datapath_tb.sv
module tape_dma_datapath_tb;
  localparam logic [7:0] DEV = 8'h5C;

  logic clk = 0, rst_n = 0;
  logic ctrl_load = 0, ctrl_write_mode = 0, bus_own_n = 1, xfer_done = 0, blk_end_n = 1;
  logic [15:0] bus_din_n = '1, fmt_in_data = '0;
  logic fmt_out_ready = 0, fmt_in_valid = 0, irq_ack = 0;
  logic [15:0] bus_dout_n;
  logic [2:0]  bus_strobe;
  logic word_req, write_armed, fmt_out_valid, fmt_in_ready, irq_req, overrun;
  logic [7:0]  fmt_out_data;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tape_dma_datapath #(.DEV_NUM(DEV)) u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs change at negedge; registered results are read 1 ns after the next posedge
  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic drv();
    @(negedge clk); #1;
  endtask

  task automatic t_reset();
    chk(!write_armed && !fmt_out_valid && !irq_req && !overrun, "R1 flags", {write_armed,fmt_out_valid,irq_req,overrun}, 0);
    chk(bus_strobe == 0 && bus_dout_n == 16'hFFFF, "R1 bus", {bus_strobe, bus_dout_n}, {3'b0,16'hFFFF});
  endtask

  task automatic t_write();
    drv(); bus_own_n = 0; ctrl_load = 1; ctrl_write_mode = 1;
    step(); drv(); ctrl_load = 0;
    chk(write_armed && word_req, "R2 arm", {write_armed,word_req}, 2'b11);
    bus_din_n = ~16'h12A5; xfer_done = 1; #1;
    chk(bus_strobe == 0, "R10 no drive on capture", bus_strobe, 0);
    step();
    chk(fmt_out_data == 8'hA5 && fmt_out_valid, "R3 capture", {fmt_out_valid,fmt_out_data}, {1'b1,8'hA5});
    chk(!write_armed && !word_req, "R3 busy cleared", write_armed, 0);
    drv(); xfer_done = 0; step(); step();
    chk(fmt_out_valid && fmt_out_data == 8'hA5, "R5 hold", {fmt_out_valid,fmt_out_data}, {1'b1,8'hA5});
    drv(); bus_din_n = ~16'h0033; xfer_done = 1; step(); drv(); xfer_done = 0;
    chk(fmt_out_data == 8'hA5 && !overrun, "R4 ignore unarmed", fmt_out_data, 8'hA5);
    fmt_out_ready = 1; step(); drv(); fmt_out_ready = 0;
    chk(!fmt_out_valid && write_armed && word_req, "R5 accept rearms", {fmt_out_valid,write_armed,word_req}, 3'b011);
  endtask

  task automatic t_unowned();
    drv(); bus_own_n = 1; bus_din_n = ~16'h00C3; xfer_done = 1; #1;
    chk(!word_req && bus_strobe == 0, "R11 unowned", {word_req,bus_strobe}, 0);
    step(); drv(); xfer_done = 0;
    chk(!fmt_out_valid && fmt_out_data == 8'hA5, "R4 ignore unowned", {fmt_out_valid,fmt_out_data}, {1'b0,8'hA5});
    bus_own_n = 0;
  endtask

  task automatic t_overrun();
    bus_din_n = ~16'h0011; xfer_done = 1; step(); drv(); xfer_done = 0;
    ctrl_load = 1; ctrl_write_mode = 1; step(); drv(); ctrl_load = 0;
    bus_din_n = ~16'h0022; xfer_done = 1; step(); drv(); xfer_done = 0;
    chk(overrun && fmt_out_data == 8'h22, "R6 overrun", {overrun,fmt_out_data}, {1'b1,8'h22});
    step();
    chk(overrun, "R6 sticky", overrun, 1);
    fmt_out_ready = 1; ctrl_load = 1; ctrl_write_mode = 1; step(); drv();
    ctrl_load = 0; fmt_out_ready = 0;
    chk(!overrun && !fmt_out_valid, "R6 clear", {overrun,fmt_out_valid}, 0);
  endtask

  task automatic t_read();
    ctrl_load = 1; ctrl_write_mode = 0; step(); drv(); ctrl_load = 0;
    chk(!write_armed && !word_req, "R2 read mode", write_armed, 0);
    fmt_in_data = 16'h5A3C; fmt_in_valid = 1; #1;
    chk(bus_strobe == 3'b111 && bus_dout_n == ~16'h5A3C, "R7 drive", bus_dout_n, ~16'h5A3C);
    chk(!fmt_in_ready, "R7 ready idle", fmt_in_ready, 0);
    xfer_done = 1; #1;
    chk(fmt_in_ready, "R7 ready on xfer", fmt_in_ready, 1);
    step(); drv(); xfer_done = 0; fmt_in_valid = 0; #1;
    chk(bus_strobe == 0 && bus_dout_n == 16'hFFFF, "R7 release", bus_dout_n, 16'hFFFF);
  endtask

  task automatic t_end();
    ctrl_load = 1; ctrl_write_mode = 1; step(); drv(); ctrl_load = 0;
    blk_end_n = 0; bus_din_n = ~16'h0077; xfer_done = 1; #1;
    chk(!word_req && bus_strobe == 0, "R8 end blocks", word_req, 0);
    step(); drv(); blk_end_n = 1; xfer_done = 0;
    chk(!write_armed && irq_req && !fmt_out_valid, "R8 irq", {write_armed,irq_req,fmt_out_valid}, 3'b010);
    irq_ack = 1; #1;
    chk(bus_strobe == 3'b111 && bus_dout_n == ~{8'h00, DEV}, "R9 devnum", bus_dout_n, ~{8'h00, DEV});
    drv(); irq_ack = 0; #1;
    chk(bus_strobe == 0, "R9 ack released", bus_strobe, 0);
    bus_own_n = 1; irq_ack = 1; #1;
    chk(bus_dout_n == ~{8'h00, DEV}, "R11 ack unowned", bus_dout_n, ~{8'h00, DEV});
    drv(); irq_ack = 0; ctrl_load = 1; step(); drv(); ctrl_load = 0;
    chk(!irq_req, "R2 clears irq", irq_req, 0);
  endtask

  initial begin
    fork
      begin
        #20; t_reset();
        rst_n = 1;
        t_write();
        t_unowned();
        t_overrun();
        t_read();
        t_end();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule